// File: doc/BRIEF.md
# MII Management Transaction Engine

This block gives a host a path to the registers of Ethernet PHYs over the two-wire management pins, the management clock (MDC) and the bidirectional management data line (MDIO). The host first loads an address register that holds a 5-bit PHY address and a 5-bit register address. Any host read or write of the separate data register then launches one management transaction to that target. Reads return their result in the data register, and writes carry the host's write data.

For an external PHY the block shifts out a standard clause-22 frame on the pins and captures read data from the PHY. One PHY address is reserved for the PHY built into the same chip. Accesses to that address are served through an internal request/acknowledge register port, and the external pins stay quiet for the whole access. While a transaction is running the block raises a busy flag. A single further access is held in a one-entry slot and runs when the current one ends.

Top module: `mdio_xact_engine`

## Requirements
- R1: A host write with host_sel=0 loads the register address from host_wdata bits 4:0 and the PHY address from bits 9:5, and ignores bits 15:10. A host read with host_sel=0 returns {6'b0, PHY address, register address} on host_rdata one cycle later.
- R2: A host read or write with host_sel=1 starts one transaction (host_we=1 means write). busy is high from the cycle after that access until the cycle in which xact_done pulses for it, and busy is low once no transaction is running or pending.
- R3: An external frame is 64 MDC bits, most significant first: 32 ones, start code 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register address, 2 turnaround bits, then 16 data bits. mdio_oe is high through the register address and is low whenever the block is idle.
- R4: On an external read the block releases MDIO (mdio_oe=0) for the turnaround and the 16 data bits. It samples mdio_i at each rising MDC edge of the data bits, and the 16-bit result appears on mgmt_data in the cycle in which xact_done pulses.
- R5: On an external write the block drives 1 then 0 in the turnaround and then the 16 write data bits, keeping mdio_oe high for all 64 bits.
- R6: MDC has a period of 2*MDC_HALF system clocks during a frame and is low while idle. mdio_o changes only in cycles where mdc is low.
- R7: PHY address 5'b11111 produces no frame. Instead ip_req pulses for exactly one cycle with ip_we, ip_regad and ip_wdata valid, and mdc and mdio_oe stay low. The transaction ends on ip_ack, and a read loads ip_rdata into mgmt_data in the xact_done cycle.
- R8: A data-register access made while busy, with the pending slot free, runs after the current transaction. It uses the PHY and register addresses that were held at the time of the access, even if the address register changes later.
- R9: A data-register access made while a transaction is running and the pending slot is already full is discarded. It produces no frame, no ip_req and no xact_done.
- R10: After reset, busy, xact_done, mdc, mdio_oe and ip_req are low and mgmt_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address register, 1 = data register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid one cycle after a read |
| mgmt_data | output | 16 | Data register: result of the last completed read |
| busy | output | 1 | A transaction is running or pending |
| xact_done | output | 1 | One-cycle pulse when a transaction completes |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| ip_req | output | 1 | Internal register port request pulse |
| ip_we | output | 1 | Internal port write flag |
| ip_regad | output | 5 | Internal port register address |
| ip_wdata | output | 16 | Internal port write data |
| ip_ack | input | 1 | Internal port acknowledge |
| ip_rdata | input | 16 | Internal port read data |

## Verification
The bench targets back-to-back data-register accesses. A design that does not take a snapshot of the address at access time sends the queued frame to the wrong register. A design that does not discard the third access emits an extra frame. The turnaround is compared bit by bit: a design that drives during a read turnaround, or sends the wrong pattern on a write, fails the enable and bit compares. Accesses to the reserved address are checked for silence on the pins, which catches any design that leaks a frame. The PHY model returns data derived from the captured address, so a bit-order or off-by-one sampling error shows as a wrong read value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_POS     = PRE_BITS + 4 + PHY_W + REG_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam logic [PHY_W-1:0] INT_PHY_ADDR = '1;

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mgmt_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXT,
    ST_INT_WAIT
  } eng_state_t;
endpackage

// File: rtl/mdc_pacer.sv
module mdc_pacer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] TA_IDX   = IW'(TA_POS);
  localparam logic [IW-1:0] DATA_IDX = IW'(DATA_POS);

  logic                  tick;
  logic [FRAME_BITS-1:0] sr;
  logic [IW-1:0]         bit_idx;
  logic [IW-1:0]         nxt_idx;
  logic                  is_rd;
  logic [DATA_W-1:0]     rd_sr;
  logic [FRAME_BITS-1:0] frame;

  mdc_pacer #(.HALF(HALF)) u_pacer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  always_comb begin
    frame = {{PRE_BITS{1'b1}}, 2'b01,
             cmd.wr ? 2'b01 : 2'b10,
             cmd.phy, cmd.regad,
             cmd.wr ? 2'b10 : 2'b11,
             cmd.wr ? cmd.wdata : {DATA_W{1'b1}}};
    nxt_idx = bit_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      bit_idx <= '0;
      is_rd   <= 1'b0;
      sr      <= '0;
      rd_sr   <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          mdc     <= 1'b0;
          sr      <= frame;
          mdio_o  <= frame[FRAME_BITS-1];
          mdio_oe <= 1'b1;
          bit_idx <= '0;
          is_rd   <= !cmd.wr;
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (is_rd && bit_idx >= DATA_IDX) rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bit_idx == LAST_BIT) begin
            run     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b1;
            rdata   <= rd_sr;
          end else begin
            bit_idx <= nxt_idx;
            sr      <= {sr[FRAME_BITS-2:0], 1'b0};
            mdio_o  <= sr[FRAME_BITS-2];
            mdio_oe <= !(is_rd && nxt_idx >= TA_IDX);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_cmd_slot.sv
module mgmt_cmd_slot
  import mdio_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  mgmt_cmd_t push_cmd,
  input  logic      pop,
  output logic      valid,
  output mgmt_cmd_t head
);
  logic take;
  assign take = push && (!valid || pop);

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (take) valid <= 1'b1;
    else if (pop) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) head <= push_cmd;
  end
endmodule

// File: rtl/mdio_xact_engine.sv
module mdio_xact_engine
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_en,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic [15:0] mgmt_data,
  output logic        busy,
  output logic        xact_done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        ip_req,
  output logic        ip_we,
  output logic [4:0]  ip_regad,
  output logic [15:0] ip_wdata,
  input  logic        ip_ack,
  input  logic [15:0] ip_rdata
);
  eng_state_t        state;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  regad_q;
  logic              cur_rd;
  logic              data_acc;
  logic              launch;
  logic              launch_ext;
  logic              slot_valid;
  mgmt_cmd_t         slot_head;
  mgmt_cmd_t         new_cmd;
  logic              sh_run;
  logic              sh_done;
  logic [DATA_W-1:0] sh_rdata;
  logic              int_phase;

  assign data_acc   = host_en && host_sel;
  assign launch     = (state == ST_IDLE) && slot_valid;
  assign launch_ext = launch && (slot_head.phy != INT_PHY_ADDR);
  assign int_phase  = (state == ST_INT_WAIT);
  assign busy       = (state != ST_IDLE) || slot_valid;

  always_comb begin
    new_cmd.wr    = host_we;
    new_cmd.phy   = phy_q;
    new_cmd.regad = regad_q;
    new_cmd.wdata = host_wdata;
  end

  // address register: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (host_en && host_we && !host_sel) begin
      regad_q <= host_wdata[REG_W-1:0];
      phy_q   <= host_wdata[REG_W+PHY_W-1:REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_en && !host_we)
      host_rdata <= host_sel ? mgmt_data : {{(16-PHY_W-REG_W){1'b0}}, phy_q, regad_q};
  end

  mgmt_cmd_slot u_slot (
    .clk      (clk),
    .rst      (rst),
    .push     (data_acc),
    .push_cmd (new_cmd),
    .pop      (launch),
    .valid    (slot_valid),
    .head     (slot_head)
  );

  mdio_frame_shifter #(.HALF(MDC_HALF)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (launch_ext),
    .cmd     (slot_head),
    .mdio_i  (mdio_i),
    .run     (sh_run),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (sh_done),
    .rdata   (sh_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_rd    <= 1'b0;
      xact_done <= 1'b0;
      mgmt_data <= '0;
      ip_req    <= 1'b0;
      ip_we     <= 1'b0;
      ip_regad  <= '0;
      ip_wdata  <= '0;
    end else begin
      xact_done <= 1'b0;
      ip_req    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            cur_rd <= !slot_head.wr;
            if (launch_ext) begin
              state <= ST_EXT;
            end else begin
              state    <= ST_INT_WAIT;
              ip_req   <= 1'b1;
              ip_we    <= slot_head.wr;
              ip_regad <= slot_head.regad;
              ip_wdata <= slot_head.wdata;
            end
          end
        end
        ST_EXT: begin
          if (sh_done && !sh_run) begin
            state     <= ST_IDLE;
            xact_done <= 1'b1;
            if (cur_rd) mgmt_data <= sh_rdata;
          end
        end
        ST_INT_WAIT: begin
          if (ip_ack && !ip_req) begin
            state     <= ST_IDLE;
            xact_done <= 1'b1;
            if (cur_rd) mgmt_data <= ip_rdata;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_xact_checker.sv
module mdio_xact_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic xact_done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic ip_req,
  input logic int_phase
);
  p_mdio_low_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  p_mdc_needs_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mdc |-> busy);

  p_oe_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  p_pins_quiet_int_r7: assert property (@(posedge clk) disable iff (rst)
    int_phase |-> (!mdc && !mdio_oe));

  p_req_single_r7: assert property (@(posedge clk) disable iff (rst)
    ip_req |=> !ip_req);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
    xact_done |-> $past(busy));
endmodule

bind mdio_xact_engine mdio_xact_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .xact_done (xact_done),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .ip_req    (ip_req),
  .int_phase (int_phase)
);

// File: tb/tb_mdio_xact_engine.sv
module tb_mdio_xact_engine;
  localparam int HALF = 2;

  typedef struct {
    bit          is_int;
    bit          wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } item_t;

  logic        clk = 0, rst = 1;
  logic        host_en = 0, host_we = 0, host_sel = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata, mgmt_data;
  logic        busy, xact_done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1;
  logic        ip_req, ip_we;
  logic [4:0]  ip_regad;
  logic [15:0] ip_wdata;
  logic        ip_ack = 0;
  logic [15:0] ip_rdata = 0;

  int checks = 0, errors = 0, frames = 0, cyc = 0;
  bit finished = 0;
  item_t exp_q[$];
  item_t last;
  logic [127:0] cap_q[$];
  logic [63:0] fr, oe;
  int pos = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_xact_engine #(.MDC_HALF(HALF)) dut (.*);

  function automatic logic [15:0] phy_reply(logic [4:0] p, logic [4:0] r);
    return {1'b1, r, p, 5'b10101};
  endfunction

  function automatic logic [15:0] int_reply(logic [4:0] r);
    return {8'hC3, 3'b000, r};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // PHY model: capture bits on rising MDC, drive read data after falling MDC
  initial forever begin
    @(posedge mdc);
    fr[63-pos] = mdio_o;
    oe[63-pos] = mdio_oe;
    if (pos == 63) begin
      cap_q.push_back({fr, oe});
      frames++;
      pos = 0;
    end else pos++;
  end

  initial forever begin
    @(negedge mdc);
    if (pos >= 48 && fr[29:28] == 2'b10)
      mdio_i = phy_reply(fr[27:23], fr[22:18])[63-pos];
    else mdio_i = 1'b1;
  end

  // internal register port responder
  initial forever begin
    @(negedge clk);
    if (ip_req) begin
      repeat (2) @(negedge clk);
      ip_rdata = int_reply(ip_regad);
      ip_ack = 1;
      @(negedge clk);
      ip_ack = 0;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (!rst && cap_q.size() > 0) begin
      logic [127:0] c;
      logic [63:0] f, e, expf;
      item_t it;
      c = cap_q.pop_front();
      f = c[127:64];
      e = c[63:0];
      if (exp_q.size() == 0) chk(0, "R9", "unexpected frame", f, 0);
      else begin
        it = exp_q.pop_front();
        last = it;
        chk(!it.is_int, "R7", "frame for internal address", f, 0);
        expf = {32'hFFFF_FFFF, 2'b01, it.wr ? 2'b01 : 2'b10, it.phy, it.regad,
                it.wr ? 2'b10 : 2'b11, it.wr ? it.data : 16'hFFFF};
        chk(f[63:18] == expf[63:18], "R3", "frame header", f, expf);
        chk(e[63:18] == '1, "R3", "header drive enable", e, 64'hFFFF_FFFF_FFFC_0000);
        if (it.wr) begin
          chk(f[17:0] == expf[17:0], "R5", "turnaround and data", f, expf);
          chk(e[17:0] == '1, "R5", "write drive enable", e, '1);
        end else
          chk(e[17:0] == '0, "R4", "read release", e, 64'hFFFF_FFFF_FFFC_0000);
      end
    end
    if (!rst && ip_req) begin
      item_t it;
      chk(!mdc && !mdio_oe, "R7", "pins idle on internal access", {mdc, mdio_oe}, 0);
      if (exp_q.size() == 0) chk(0, "R9", "unexpected ip_req", ip_regad, 0);
      else begin
        it = exp_q.pop_front();
        last = it;
        chk(it.is_int, "R7", "ip_req for external address", 1, 0);
        chk(ip_we == it.wr && ip_regad == it.regad, "R7", "ip_we/ip_regad",
            {ip_we, ip_regad}, {it.wr, it.regad});
        if (it.wr) chk(ip_wdata == it.data, "R7", "ip_wdata", ip_wdata, it.data);
      end
    end
    if (!rst && xact_done && !last.wr)
      chk(mgmt_data == last.data, last.is_int ? "R7" : "R4", "read result", mgmt_data, last.data);
  end

  task automatic write_addr(logic [4:0] p, logic [4:0] r);
    @(negedge clk);
    host_en = 1; host_we = 1; host_sel = 0;
    host_wdata = {6'b101101, p, r};
    @(negedge clk);
    host_en = 0;
  endtask

  // driver: one data-register access; pushes the expected item unless dropped
  task automatic access(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d, bit expect_run);
    item_t it;
    it.is_int = (p == 5'h1F);
    it.wr = wr;
    it.phy = p;
    it.regad = r;
    it.data = wr ? d : (it.is_int ? int_reply(r) : phy_reply(p, r));
    if (expect_run) exp_q.push_back(it);
    host_en = 1; host_we = wr; host_sel = 1; host_wdata = d;
    @(negedge clk);
    host_en = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int f0, t1, t2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !xact_done && !mdc && !mdio_oe && !ip_req && mgmt_data == 0, "R10",
        "reset state", {busy, xact_done, mdc, mdio_oe, ip_req, mgmt_data}, 0);

    // R1 address register readback, upper bits ignored
    write_addr(5'h05, 5'h1A);
    host_en = 1; host_we = 0; host_sel = 0;
    @(negedge clk);
    host_en = 0;
    chk(host_rdata == {6'b0, 5'h05, 5'h1A}, "R1", "address readback", host_rdata, {6'b0, 5'h05, 5'h1A});

    // R2 / R5 external write
    access(1, 5'h05, 5'h1A, 16'hA5C3, 1);
    chk(busy, "R2", "busy after access", busy, 1);
    wait_idle();
    chk(!busy && !mdc && !mdio_oe, "R2", "idle after write", {busy, mdc, mdio_oe}, 0);

    // R4 / R6 external read with MDC period measurement
    write_addr(5'h12, 5'h03);
    access(0, 5'h12, 5'h03, 0, 1);
    @(posedge mdc); t1 = cyc;
    @(posedge mdc); t2 = cyc;
    chk(t2 - t1 == 2 * HALF, "R6", "mdc period", t2 - t1, 2 * HALF);
    wait_idle();
    chk(!mdc, "R6", "mdc low when idle", mdc, 0);

    // R7 internal write and read
    f0 = frames;
    write_addr(5'h1F, 5'h09);
    access(1, 5'h1F, 5'h09, 16'h1234, 1);
    wait_idle();
    write_addr(5'h1F, 5'h11);
    access(0, 5'h1F, 5'h11, 0, 1);
    wait_idle();
    chk(frames == f0, "R7", "no frame for internal PHY", frames, f0);

    // R8 queued access uses the address held at access time
    write_addr(5'h0C, 5'h01);
    access(0, 5'h0C, 5'h01, 0, 1);
    write_addr(5'h17, 5'h0E);
    access(1, 5'h17, 5'h0E, 16'h5A0F, 1);
    write_addr(5'h02, 5'h02);
    chk(busy, "R8", "busy with pending access", busy, 1);
    wait_idle();

    // R8 external then queued internal
    write_addr(5'h03, 5'h04);
    access(1, 5'h03, 5'h04, 16'h0F0F, 1);
    write_addr(5'h1F, 5'h07);
    access(0, 5'h1F, 5'h07, 0, 1);
    wait_idle();

    // R9 third access while running with slot full is dropped
    f0 = frames;
    write_addr(5'h08, 5'h10);
    access(1, 5'h08, 5'h10, 16'hBEEF, 1);
    access(0, 5'h08, 5'h10, 0, 1);
    access(1, 5'h08, 5'h10, 16'hDEAD, 0);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(frames == f0 + 2, "R9", "dropped access made no frame", frames, f0 + 2);
    chk(!busy && !mdc, "R9", "quiet after drop", {busy, mdc}, 0);
    chk(exp_q.size() == 0, "R2", "all expected transactions seen", exp_q.size(), 0);
    summary();
  end
endmodule